// File: doc/BRIEF.md
# Bit-Selected-Period PWM Generator

This block drives one pulse-width-modulated output from a free-running 8-bit counter. The counter advances only on cycles where a slow reference tick is asserted. The period is not held in a register of its own. Instead, a 2-bit period-select field picks which counter bit sends the counter back to zero. That gives periods of 128, 64, 32 or 16 ticks.

The bits below the chosen reset bit form the effective count. The output is high while that count is below a 7-bit duty value. Software programs the block through a byte-wide register port with write enable, address, write data and read data. Address 0 holds the enable bit and the period select. Address 1 holds the duty value.

Every write acts on the very next clock cycle. There is no double buffering. A change of period select keeps the running count.

Top module: `pwm_bitsel_top`

## Requirements
- R1: Synchronous reset clears both registers and the counter, so both registers read 0x00 and `pwm_out` is low after reset.
- R2: A write to address 0 stores bit 7 as the enable and bits [1:0] as the period select `p`. A read of address 0 returns those three bits in the same positions, with bits [6:2] reading zero.
- R3: A write to address 1 stores bits [6:0] as the duty value. A read of address 1 returns it, with bit 7 reading zero.
- R4: While enabled, the counter advances by one only on cycles with `ref_tick` high. When the incremented value has bit `7-p` set, the counter goes to zero instead, so the period is 128>>p ticks.
- R5: While enabled, `pwm_out` is high exactly when the counter's low `7-p` bits, read as an unsigned number, are below the duty value. A duty of 0 keeps the output low.
- R6: A duty at or above 2^(7-p) keeps the output high for the whole period. With p=0, the largest duty (127) gives 127 high ticks out of 128.
- R7: With the enable bit at 0, `pwm_out` is low and the counter is held at zero. After enable is set, counting restarts from zero.
- R8: Writing a new period select leaves the counter value untouched. Counting continues from that value under the new reset bit.
- R9: A new duty value acts on the output in the cycle after the write, even in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Single-cycle count enable from the slow reference |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 = control, 1 = duty |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pwm_out | output | 1 | PWM output |

## Verification
Two things can land in the same clock cycle: a register write and a counter step. The worst case is a period-select write on the very tick where the count wraps. The other is a duty write on a tick that moves the count across the new threshold.

The bench drives these coincident cycles on purpose. A scoreboard predicts every following cycle's output from the rules above. The rules say the counter step uses the settings held before the edge, and the write shows from the next cycle on.

// File: rtl/pwm_bitsel_pkg.sv
package pwm_bitsel_pkg;

    localparam int CNT_W_DEF  = 8;
    localparam int PS_W_DEF   = 2;
    localparam int DATA_W_DEF = 8;
    localparam int ADDR_W_DEF = 1;

    // Register select encoding seen on the addr port
    typedef enum logic [0:0] {
        SEL_CTRL = 1'b0,
        SEL_DUTY = 1'b1
    } reg_sel_e;

    // Number of counter bits below the reset bit chosen by ps
    function automatic int live_bits(input int cnt_w, input int ps);
        return cnt_w - 1 - ps;
    endfunction

    // Full-period length in ticks for a given select
    function automatic int span_ticks(input int cnt_w, input int ps);
        return 1 << live_bits(cnt_w, ps);
    endfunction

endpackage

// File: rtl/pwm_bitsel_regs.sv
module pwm_bitsel_regs
    import pwm_bitsel_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int PS_W   = PS_W_DEF,
    parameter int DUTY_W = DATA_W - 1,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              run_en,
    output logic [PS_W-1:0]   ps_sel,
    output logic [DUTY_W-1:0] duty,
    output logic [DATA_W-1:0] rdata
);

    localparam int EN_BIT  = DATA_W - 1;
    localparam int GAP_W   = DATA_W - 1 - PS_W;
    localparam int DPAD_W  = DATA_W - DUTY_W;

    typedef struct packed {
        logic            en;
        logic [PS_W-1:0] ps;
    } ctrl_t;

    ctrl_t              ctrl_q;
    logic [DUTY_W-1:0]  duty_q;
    logic               hit_ctrl;
    logic               hit_duty;

    assign hit_ctrl = wr_en && (addr == ADDR_W'(SEL_CTRL));
    assign hit_duty = wr_en && (addr == ADDR_W'(SEL_DUTY));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            duty_q <= '0;
        end else begin
            if (hit_ctrl) begin
                ctrl_q.en <= wdata[EN_BIT];
                ctrl_q.ps <= wdata[PS_W-1:0];
            end
            if (hit_duty) begin
                duty_q <= wdata[DUTY_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(SEL_CTRL)) begin
            rdata = {ctrl_q.en, {GAP_W{1'b0}}, ctrl_q.ps};
        end else if (addr == ADDR_W'(SEL_DUTY)) begin
            rdata = {{DPAD_W{1'b0}}, duty_q};
        end
    end

    assign run_en = ctrl_q.en;
    assign ps_sel = ctrl_q.ps;
    assign duty   = duty_q;

    // R1: reset leaves both registers cleared
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0 && duty_q == '0));

    // R3: a duty write is captured for the next cycle
    assert_duty_write_R3: assert property (@(posedge clk) disable iff (rst)
        hit_duty |=> duty_q == $past(wdata[DUTY_W-1:0]));

    // R2: a control write is captured for the next cycle
    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
        hit_ctrl |=> (run_en == $past(wdata[EN_BIT]) && ps_sel == $past(wdata[PS_W-1:0])));

endmodule

// File: rtl/pwm_bitsel_counter.sv
module pwm_bitsel_counter
    import pwm_bitsel_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int PS_W  = PS_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             ref_tick,
    input  logic [PS_W-1:0]  ps_sel,
    output logic [CNT_W-1:0] cnt
);

    localparam int NUM_PS = 1 << PS_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic [NUM_PS-1:0] wrap_hit;

    assign cnt_inc = cnt_q + CNT_W'(1);

    // One candidate reset bit per period-select value
    for (genvar g = 0; g < NUM_PS; g++) begin : g_rst_bit
        assign wrap_hit[g] = cnt_inc[CNT_W-1-g];
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            cnt_q <= '0;
        end else if (ref_tick) begin
            cnt_q <= wrap_hit[ps_sel] ? '0 : cnt_inc;
        end
    end

    assign cnt = cnt_q;

    // R7: a disabled block holds its counter at zero
    assert_hold_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> cnt_q == '0);

    // R4: without a tick the count does not move, whatever the select does (R8)
    assert_no_tick_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (run_en && !ref_tick) |=> $stable(cnt_q));

    // R4: a tick moves the count either up by one or back to zero
    assert_tick_step_R4: assert property (@(posedge clk) disable iff (rst)
        (run_en && ref_tick) |=> (cnt_q == '0 || cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/pwm_bitsel_cmp.sv
module pwm_bitsel_cmp
    import pwm_bitsel_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int PS_W   = PS_W_DEF,
    parameter int DUTY_W = CNT_W - 1
) (
    input  logic              run_en,
    input  logic [PS_W-1:0]   ps_sel,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DUTY_W-1:0] duty,
    input  logic              clk,
    input  logic              rst,
    output logic              pwm
);

    localparam int NUM_PS = 1 << PS_W;

    logic [CNT_W-1:0] live_mask [NUM_PS];
    logic [CNT_W-1:0] span      [NUM_PS];
    logic [CNT_W-1:0] eff;
    logic             below;

    // Mask of the bits under the chosen reset bit, per select value
    for (genvar g = 0; g < NUM_PS; g++) begin : g_mask
        assign span[g]      = CNT_W'(span_ticks(CNT_W, g));
        assign live_mask[g] = span[g] - CNT_W'(1);
    end

    assign eff   = cnt & live_mask[ps_sel];
    assign below = eff < CNT_W'(duty);
    assign pwm   = run_en && below;

    // R5: zero duty never drives the output high
    assert_zero_duty_low_R5: assert property (@(posedge clk) disable iff (rst)
        (duty == '0) |-> !pwm);

    // R6: a duty covering the whole period keeps the output high
    assert_full_high_R6: assert property (@(posedge clk) disable iff (rst)
        (run_en && CNT_W'(duty) >= span[ps_sel]) |-> pwm);

endmodule

// File: rtl/pwm_bitsel_top.sv
module pwm_bitsel_top
    import pwm_bitsel_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int PS_W   = PS_W_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              pwm_out
);

    localparam int DUTY_W = CNT_W - 1;

    logic              run_en;
    logic [PS_W-1:0]   ps_sel;
    logic [DUTY_W-1:0] duty;
    logic [CNT_W-1:0]  cnt;

    pwm_bitsel_regs #(
        .DATA_W (DATA_W),
        .PS_W   (PS_W),
        .DUTY_W (DUTY_W),
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .run_en (run_en),
        .ps_sel (ps_sel),
        .duty   (duty),
        .rdata  (rdata)
    );

    pwm_bitsel_counter #(
        .CNT_W (CNT_W),
        .PS_W  (PS_W)
    ) i_counter (
        .clk      (clk),
        .rst      (rst),
        .run_en   (run_en),
        .ref_tick (ref_tick),
        .ps_sel   (ps_sel),
        .cnt      (cnt)
    );

    pwm_bitsel_cmp #(
        .CNT_W  (CNT_W),
        .PS_W   (PS_W),
        .DUTY_W (DUTY_W)
    ) i_cmp (
        .run_en (run_en),
        .ps_sel (ps_sel),
        .cnt    (cnt),
        .duty   (duty),
        .clk    (clk),
        .rst    (rst),
        .pwm    (pwm_out)
    );

    // R7: output low while the enable bit reads back as zero
    assert_off_low_R7: assert property (@(posedge clk) disable iff (rst)
        !rdata[DATA_W-1] && addr == ADDR_W'(SEL_CTRL) |-> !pwm_out);

endmodule

// File: tb/test_pwm_bitsel_top.sv
`timescale 1ns/1ps
module test_pwm_bitsel_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       pwm_out;

    always #2.5 clk = ~clk;

    pwm_bitsel_top i_pwm_bitsel_top (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .pwm_out  (pwm_out)
    );

    typedef struct {
        bit    exp;
        string req;
    } sb_item_t;

    sb_item_t   sb [$];
    int         n_tests = 0;
    int         n_fail  = 0;
    bit         done    = 0;
    string      cur_req = "R1";
    bit         last_obs;

    // Requirement-level model state
    bit         m_en;
    bit [1:0]   m_ps;
    bit [6:0]   m_duty;
    bit [7:0]   m_cnt;

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_pwm();
        bit [7:0] mask;
        mask = (8'd1 << (7 - m_ps)) - 8'd1;
        return m_en && ((m_cnt & mask) < {1'b0, m_duty});
    endfunction

    // Driver: one clock cycle of stimulus, model update, push expectation
    task automatic step(bit r, bit t, bit w, bit a, bit [7:0] d);
        bit [7:0] n;
        @(negedge clk);
        rst = r; ref_tick = t; wr_en = w; addr = a; wdata = d;
        @(posedge clk);
        if (r) begin
            m_en = 0; m_ps = 0; m_duty = 0; m_cnt = 0;
        end else begin
            if (!m_en) m_cnt = 0;
            else if (t) begin
                n = m_cnt + 8'd1;
                m_cnt = n[7 - m_ps] ? 8'd0 : n;
            end
            if (w) begin
                if (!a) begin m_en = d[7]; m_ps = d[1:0]; end
                else m_duty = d[6:0];
            end
        end
        sb.push_back('{exp_pwm(), cur_req});
        #1;
        last_obs = pwm_out;
        ref_tick = 0; wr_en = 0;
    endtask

    task automatic wr(bit a, bit [7:0] d);
        step(0, 0, 1, a, d);
    endtask

    task automatic rd_check(string req, bit a, int exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    // Runs n ticks, returns high count and first tick index that is high
    task automatic run_ticks(int n, output int highs, output int first_hi);
        highs = 0; first_hi = -1;
        for (int i = 1; i <= n; i++) begin
            step(0, 1, 0, 0, 8'h00);
            if (last_obs) begin
                highs++;
                if (first_hi < 0) first_hi = i;
            end
        end
    endtask

    // Monitor: compare each cycle's output against the scoreboard
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            sb_item_t it;
            it = sb.pop_front();
            check({it.req, " scoreboard"}, pwm_out, it.exp);
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int h, f;
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 8'h00);
        step(0, 0, 0, 0, 8'h00);

        cur_req = "R1";
        rd_check("R1 ctrl after reset", 0, 8'h00);
        rd_check("R1 duty after reset", 1, 8'h00);
        check("R1 pwm after reset", pwm_out, 0);

        cur_req = "R2";
        wr(0, 8'hFF);
        rd_check("R2 ctrl readback", 0, 8'h83);
        wr(0, 8'h00);
        rd_check("R2 ctrl cleared", 0, 8'h00);

        cur_req = "R3";
        wr(1, 8'hFF);
        rd_check("R3 duty readback", 1, 8'h7F);
        wr(1, 8'h2A);
        rd_check("R3 duty readback 2", 1, 8'h2A);

        cur_req = "R4";
        wr(1, 8'h01);
        for (int p = 0; p < 4; p++) begin
            wr(0, 8'h00);
            wr(0, 8'h80 | p[7:0]);
            run_ticks(140, h, f);
            check("R4 period ticks", f, 128 >> p);
        end
        wr(0, 8'h00); wr(0, 8'h82);
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 8'h00);
        run_ticks(32, h, f);
        check("R4 no-tick cycles ignored", f, 32);

        cur_req = "R5";
        wr(0, 8'h00); wr(1, 8'd20); wr(0, 8'h81);
        run_ticks(64, h, f);
        check("R5 high ticks duty 20 p1", h, 20);
        wr(1, 8'd0);
        run_ticks(64, h, f);
        check("R5 high ticks duty 0", h, 0);

        cur_req = "R6";
        wr(0, 8'h00); wr(1, 8'd127); wr(0, 8'h80);
        run_ticks(128, h, f);
        check("R6 p0 max duty highs", h, 127);
        wr(0, 8'h00); wr(1, 8'd16); wr(0, 8'h83);
        run_ticks(16, h, f);
        check("R6 p3 full duty highs", h, 16);
        wr(0, 8'h00); wr(1, 8'd100); wr(0, 8'h82);
        run_ticks(32, h, f);
        check("R6 p2 oversize duty highs", h, 32);

        cur_req = "R7";
        wr(0, 8'h00); wr(1, 8'd1); wr(0, 8'h83);
        run_ticks(7, h, f);
        wr(0, 8'h03);
        check("R7 low when disabled", last_obs, 0);
        run_ticks(5, h, f);
        check("R7 ticks while disabled stay low", h, 0);
        wr(0, 8'h83);
        check("R7 restart at zero", last_obs, 1);
        run_ticks(16, h, f);
        check("R7 first wrap after restart", f, 16);

        cur_req = "R8";
        wr(0, 8'h00); wr(1, 8'd45); wr(0, 8'h80);
        run_ticks(40, h, f);
        wr(0, 8'h81);
        check("R8 still high after select change", last_obs, 1);
        run_ticks(5, h, f);
        check("R8 count kept across select", last_obs, 0);
        // select change on the wrapping tick
        wr(0, 8'h00); wr(1, 8'd1); wr(0, 8'h83);
        run_ticks(15, h, f);
        step(0, 1, 1, 0, 8'h80);
        check("R8 wrap with old select same cycle", last_obs, 1);
        run_ticks(1, h, f);
        check("R8 new select after wrap", last_obs, 0);

        cur_req = "R9";
        wr(0, 8'h00); wr(1, 8'd10); wr(0, 8'h83);
        run_ticks(5, h, f);
        check("R9 high before change", last_obs, 1);
        wr(1, 8'd3);
        check("R9 immediate duty drop", last_obs, 0);
        wr(1, 8'd12);
        check("R9 immediate duty raise", last_obs, 1);
        step(0, 1, 1, 1, 8'd6);
        check("R9 duty write with tick", last_obs, 0);

        step(0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 0, 8'h00);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule